// File: doc/BRIEF.md
# Dual-Comparator Compare-Output Timer

This block is a 16-bit up-counting timer with two comparators. It raises a sticky event flag for each comparator and drives a single output pin. The count advances by one on each clock-enable tick while the timer is enabled and the mode field selects compare-output operation. The period comparator holds an 8-bit value and looks only at the upper byte of the count, so periods come in steps of 256 ticks. The second comparator holds a full 16-bit match value, and its matches are the only events that move the output pin.

A clear-select input chooses which event returns the count to zero. With the select low, the period comparator or a natural wrap restarts the count, and either comparator may raise its flag. With the select high, a full-width match restarts the count and the period flag stays quiet. Other mode encodings keep the counter parked at zero, with no events. The pin takes a programmed starting level each time the timer is switched on.

Top module: `dual_cmp_timer`

## Requirements
- R1: While `en_i` is 1 and `mode_i` is 2'b00, the count rises by one on each cycle with `tick_i` high and holds when it is low. When `en_i` is 0 the count returns to zero, so after a re-enable the first match is counted again from zero.
- R2: A full-width match value M (nonzero) sets `match_flag_o` on the tick that takes the count to M. A value of zero never matches.
- R3: With `clr_sel_i` at 0 and a period value N from 1 to 255, the count restarts after N×256 ticks. `period_flag_o` is set on the tick that would reach N×256.
- R4: With `clr_sel_i` at 0 and a period value of 0, the count wraps after 65536 ticks and `period_flag_o` is set on that wrap.
- R5: With `clr_sel_i` at 1, the count restarts on the tick that reaches M, giving a cycle of M ticks. `period_flag_o` is never set, even when the period value lies below M.
- R6: On a full-width match, `pin_o` follows `act_i`: 2'b00 leaves it unchanged, 2'b01 drives it low, 2'b10 drives it high, and 2'b11 inverts it. A period match never changes `pin_o`.
- R7: On the first clock edge where `en_i` is 1 after having been 0, `pin_o` takes the value of `init_lvl_i`.
- R8: Each flag stays set until its clear strobe is high at a clock edge. If a new match and a clear strobe come at the same edge, the flag ends up set.
- R9: With `mode_i` other than 2'b00, the count stays at zero, no flag is set, and `pin_o` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Clock-enable tick for the count |
| en_i | input | 1 | Timer enable |
| mode_i | input | 2 | Mode select; 2'b00 is compare-output |
| clr_sel_i | input | 1 | 0: period match or wrap restarts; 1: full-width match restarts |
| act_i | input | 2 | Pin action on full-width match |
| init_lvl_i | input | 1 | Pin level loaded on enable |
| period_i | input | 8 | Period value matched against count bits 15..8 |
| match_i | input | 16 | Full-width match value |
| period_clr_i | input | 1 | Clear strobe for the period flag |
| match_clr_i | input | 1 | Clear strobe for the match flag |
| pin_o | output | 1 | Compare output pin |
| match_flag_o | output | 1 | Sticky full-width match flag |
| period_flag_o | output | 1 | Sticky period flag |

## Verification
The bench counts the ticks between enable and each flag, and the ticks between successive flags, to tell the restart sources apart. It uses a period value below the match value with the select high, which shows that the period flag is suppressed. It uses a match value below the period with the select low, which shows that the count keeps running past M to N×256. It also runs a zero period that wraps only at 65536. Each of the four pin actions is started from a level that makes a change visible. A sparse tick pattern separates counting on ticks from counting on clocks. A clear strobe placed exactly on a match edge shows which one has priority. A zero match value and a non-compare mode are checked to produce no events at all.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    localparam logic [1:0] MODE_CMP_OUT = 2'b00;

    localparam int FLAG_MATCH  = 0;
    localparam int FLAG_PERIOD = 1;
    localparam int NUM_FLAGS   = 2;

endpackage

// File: rtl/dct_count.sv
module dct_count
    import dct_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic             clr_sel_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [CNT_W-1:0] match_i,
    output logic             match_set_o,
    output logic             period_set_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic [CNT_W-1:0] nxt;
    logic             run, step, a_hit, p_hit;

    always_comb begin
        state_d = state_q;
        nxt     = state_q.cnt + 1'b1;
        run     = en_i && (mode_i == MODE_CMP_OUT);
        step    = run && tick_i;
        a_hit   = step && (match_i != '0) && (nxt == match_i);
        if (period_i == '0) begin
            p_hit = step && (&state_q.cnt);
        end else begin
            p_hit = step && (nxt[CNT_W-1 -: PER_W] == period_i);
        end
        if (!run) begin
            state_d.cnt = '0;
        end else if (tick_i) begin
            if ((clr_sel_i && a_hit) || (!clr_sel_i && p_hit)) begin
                state_d.cnt = '0;
            end else begin
                state_d.cnt = nxt;
            end
        end
        match_set_o  = a_hit;
        period_set_o = p_hit && !clr_sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R1
    idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state_q.cnt == '0);

    // R1
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(state_q.cnt) || (state_q.cnt == '0));

    // R2
    zero_match_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i == '0) |-> !match_set_o);

    // R5
    no_period_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sel_i |-> !period_set_o);

    // R9
    other_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_CMP_OUT) |-> !match_set_o && !period_set_o);

endmodule

// File: rtl/dct_flag.sv
module dct_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.flag = set_i || (state_q.flag && !clr_i);
        flag_o       = state_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !clr_i |=> flag_o);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/dct_pin.sv
module dct_pin
    import dct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       init_lvl_i,
    input  logic [1:0] act_i,
    input  logic       match_set_i,
    output logic       pin_o
);

    typedef struct packed {
        logic pin;
        logic en_prev;
    } pin_state_t;

    pin_state_t state_d, state_q;
    logic       rise;

    always_comb begin
        state_d         = state_q;
        state_d.en_prev = en_i;
        rise            = en_i && !state_q.en_prev;
        if (rise) begin
            state_d.pin = init_lvl_i;
        end else if (match_set_i) begin
            case (pin_act_e'(act_i))
                ACT_LOW:    state_d.pin = 1'b0;
                ACT_HIGH:   state_d.pin = 1'b1;
                ACT_TOGGLE: state_d.pin = !state_q.pin;
                default:    state_d.pin = state_q.pin;
            endcase
        end
        pin_o = state_q.pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R7
    enable_loads_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !state_q.en_prev |=> pin_o == $past(init_lvl_i));

    // R6
    pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_set_i && !(en_i && !state_q.en_prev) |=> $stable(pin_o));

    // R6
    pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_set_i && (act_i == ACT_TOGGLE) && state_q.en_prev |=> pin_o != $past(pin_o));

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic             clr_sel_i,
    input  logic [1:0]       act_i,
    input  logic             init_lvl_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [CNT_W-1:0] match_i,
    input  logic             period_clr_i,
    input  logic             match_clr_i,
    output logic             pin_o,
    output logic             match_flag_o,
    output logic             period_flag_o
);

    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_val;

    dct_count #(.CNT_W(CNT_W), .PER_W(PER_W)) i_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .en_i         (en_i),
        .mode_i       (mode_i),
        .clr_sel_i    (clr_sel_i),
        .period_i     (period_i),
        .match_i      (match_i),
        .match_set_o  (flag_set[FLAG_MATCH]),
        .period_set_o (flag_set[FLAG_PERIOD])
    );

    assign flag_clr[FLAG_MATCH]  = match_clr_i;
    assign flag_clr[FLAG_PERIOD] = period_clr_i;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        dct_flag i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .clr_i  (flag_clr[g]),
            .flag_o (flag_val[g])
        );
    end

    dct_pin i_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .init_lvl_i  (init_lvl_i),
        .act_i       (act_i),
        .match_set_i (flag_set[FLAG_MATCH]),
        .pin_o       (pin_o)
    );

    assign match_flag_o  = flag_val[FLAG_MATCH];
    assign period_flag_o = flag_val[FLAG_PERIOD];

endmodule

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        en_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        clr_sel_i = 1'b0;
    logic [1:0]  act_i = 2'b00;
    logic        init_lvl_i = 1'b0;
    logic [7:0]  period_i = 8'd0;
    logic [15:0] match_i = 16'd0;
    logic        period_clr_i = 1'b0;
    logic        match_clr_i = 1'b0;
    logic        pin_o, match_flag_o, period_flag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_cmp_timer i_dual_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_i), .mode_i(mode_i),
        .clr_sel_i(clr_sel_i), .act_i(act_i), .init_lvl_i(init_lvl_i),
        .period_i(period_i), .match_i(match_i), .period_clr_i(period_clr_i),
        .match_clr_i(match_clr_i), .pin_o(pin_o), .match_flag_o(match_flag_o),
        .period_flag_o(period_flag_o)
    );

    task automatic chk(input string req, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic start(input logic cs, input logic [1:0] act, input logic init,
                         input logic [7:0] per, input logic [15:0] m,
                         input logic [1:0] md, input logic tk);
        @(negedge clk);
        en_i = 1'b0; tick_i = 1'b0; match_clr_i = 1'b1; period_clr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        match_clr_i = 1'b0; period_clr_i = 1'b0;
        clr_sel_i = cs; act_i = act; init_lvl_i = init; period_i = per;
        match_i = m; mode_i = md; tick_i = tk; en_i = 1'b1;
    endtask

    task automatic wait_flag(input bit per, input int limit, output int n);
        n = limit + 1;
        for (int k = 1; k <= limit; k++) begin
            @(posedge clk);
            @(negedge clk);
            if ((per ? period_flag_o : match_flag_o) == 1'b1) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic pulse_clr(input bit per);
        if (per) period_clr_i = 1'b1; else match_clr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        period_clr_i = 1'b0; match_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R7 reset pin", int'(pin_o), 0);
        chk("R8 reset match flag", int'(match_flag_o), 0);
        chk("R8 reset period flag", int'(period_flag_o), 0);
    endtask

    task automatic t_low_sel_toggle();
        int n;
        start(1'b0, 2'b11, 1'b0, 8'd1, 16'd100, 2'b00, 1'b1);
        wait_flag(1'b0, 400, n);
        chk("R2 match tick", n, 100);
        chk("R6 toggle high", int'(pin_o), 1);
        chk("R3 period flag not yet", int'(period_flag_o), 0);
        pulse_clr(1'b0);
        wait_flag(1'b1, 400, n);
        chk("R3 period at 256", n, 155);
        chk("R6 period leaves pin", int'(pin_o), 1);
        pulse_clr(1'b1);
        wait_flag(1'b0, 400, n);
        chk("R3 restart then match", n, 99);
        chk("R6 toggle low", int'(pin_o), 0);
    endtask

    task automatic t_high_sel();
        int n;
        start(1'b1, 2'b00, 1'b0, 8'd1, 16'd300, 2'b00, 1'b1);
        wait_flag(1'b0, 700, n);
        chk("R5 first match", n, 300);
        chk("R5 no period flag", int'(period_flag_o), 0);
        pulse_clr(1'b0);
        wait_flag(1'b0, 700, n);
        chk("R5 cycle of M ticks", n, 299);
        chk("R5 still no period flag", int'(period_flag_o), 0);
    endtask

    task automatic t_actions();
        int n;
        start(1'b1, 2'b01, 1'b1, 8'd0, 16'd20, 2'b00, 1'b1);
        @(posedge clk); @(negedge clk);
        chk("R7 init level high", int'(pin_o), 1);
        wait_flag(1'b0, 100, n);
        chk("R6 drive low", int'(pin_o), 0);
        start(1'b1, 2'b10, 1'b0, 8'd0, 16'd20, 2'b00, 1'b1);
        @(posedge clk); @(negedge clk);
        chk("R7 init level low", int'(pin_o), 0);
        wait_flag(1'b0, 100, n);
        chk("R6 drive high", int'(pin_o), 1);
        start(1'b1, 2'b00, 1'b1, 8'd0, 16'd20, 2'b00, 1'b1);
        wait_flag(1'b0, 100, n);
        chk("R6 none flag set", int'(match_flag_o), 1);
        chk("R6 none keeps pin", int'(pin_o), 1);
    endtask

    task automatic t_zero_match();
        int n;
        start(1'b0, 2'b11, 1'b0, 8'd1, 16'd0, 2'b00, 1'b1);
        wait_flag(1'b0, 600, n);
        chk("R2 zero never matches", n, 601);
        chk("R2 zero keeps pin", int'(pin_o), 0);
    endtask

    task automatic t_wrap();
        int n;
        start(1'b0, 2'b00, 1'b0, 8'd0, 16'd40000, 2'b00, 1'b1);
        wait_flag(1'b1, 70000, n);
        chk("R4 wrap period", n, 65536);
    endtask

    task automatic t_set_beats_clear();
        int n;
        start(1'b1, 2'b00, 1'b0, 8'd0, 16'd5, 2'b00, 1'b1);
        wait_flag(1'b0, 50, n);
        chk("R8 first match", n, 5);
        pulse_clr(1'b0);
        chk("R8 clear strobe", int'(match_flag_o), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        match_clr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 set wins over clear", int'(match_flag_o), 1);
        match_clr_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 flag stays", int'(match_flag_o), 1);
    endtask

    task automatic t_other_mode();
        int n;
        start(1'b0, 2'b11, 1'b1, 8'd1, 16'd10, 2'b01, 1'b1);
        wait_flag(1'b0, 600, n);
        chk("R9 no match flag", n, 601);
        chk("R9 no period flag", int'(period_flag_o), 0);
        chk("R9 pin kept", int'(pin_o), 1);
    endtask

    task automatic t_reenable();
        int n;
        start(1'b0, 2'b11, 1'b0, 8'd1, 16'd100, 2'b00, 1'b1);
        repeat (50) @(posedge clk);
        @(negedge clk);
        en_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        init_lvl_i = 1'b1; en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R7 reload on enable", int'(pin_o), 1);
        wait_flag(1'b0, 400, n);
        chk("R1 count restarted", n, 99);
        chk("R6 toggle from reload", int'(pin_o), 0);
    endtask

    task automatic t_sparse_tick();
        start(1'b1, 2'b00, 1'b0, 8'd0, 16'd10, 2'b00, 1'b0);
        for (int k = 1; k <= 10; k++) begin
            repeat (2) @(posedge clk);
            @(negedge clk);
            tick_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick_i = 1'b0;
            if (k == 9) chk("R1 nine ticks no flag", int'(match_flag_o), 0);
        end
        chk("R1 tenth tick flag", int'(match_flag_o), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_low_sel_toggle();
        t_high_sel();
        t_actions();
        t_zero_match();
        t_set_beats_clear();
        t_other_mode();
        t_reenable();
        t_sparse_tick();
        t_wrap();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

endmodule